// File: doc/BRIEF.md
# History-Indexed Branch Direction Predictor

This block predicts the direction of conditional branches for a simple in-order front end. For each fetched branch it takes the program counter and a flag saying whether the branch jumps backward. It returns a taken or not-taken guess in the same cycle. In dynamic mode the guess comes from a table of 2-bit saturating counters. The table is addressed by the word-aligned low PC bits XORed with a global history of recent outcomes. In static mode backward branches are guessed taken and forward branches not taken.

The front end keeps the table index returned with each prediction and hands it back, together with the guess it used, when the branch resolves. On resolution the block nudges that counter toward the real outcome and shifts the outcome into the history. One cycle later it reports whether the guess was wrong and how many clocks the redirect costs. A wrong guess costs more for a forward branch than for a backward one. While the history fills and the counters warm up, the first passes of a loop can be mispredicted.

Top module: `hbp_top`

## Requirements
- R1: The table holds 2**IDX_W entries (256 by default). Each entry is a 2-bit counter that resets to 1 (weakly not taken). Counter values 2 and 3 predict taken; values 0 and 1 predict not taken.
- R2: `pred_idx_o` equals `pred_pc_i[PC_LSB+IDX_W-1:PC_LSB]` XOR the history register. With the defaults this is PC bits 9:2 XOR the 8-bit history. It is combinational in the same cycle.
- R3: With `mode_dyn_i`=0, `pred_taken_o` equals `pred_bwd_i`, whatever the table holds. A backward branch (`pred_bwd_i`=1) is guessed taken.
- R4: With `mode_dyn_i`=1, `pred_taken_o` is 1 exactly when the counter at `pred_idx_o` is 2 or 3. It is combinational in the same cycle.
- R5: A clock edge with `res_valid_i`=1 increments the counter at `res_idx_i` when `res_taken_i`=1 and decrements it otherwise. The counter saturates at 3 and 0, and the new value is seen from the next cycle.
- R6: The same edge shifts the history left by one, with `res_taken_i` entering at bit 0. Without `res_valid_i` the history holds.
- R7: One cycle after a resolution, `mispred_o` is 1 when `res_pred_i` differs from `res_taken_i`. `penalty_o` is then 2 for a backward branch (`res_bwd_i`=1) and 3 for a forward branch. Both outputs are 0 after a correct resolution or a cycle without one.
- R8: Reset (`rst_ni`=0) clears the history to 0, sets every counter to 1 and drives `mispred_o` and `penalty_o` to 0.
- R9: The table and the history train in static mode exactly as in dynamic mode.
- R10: A backward loop branch at a fixed PC that keeps resolving taken is mispredicted in dynamic mode on its early passes. It is predicted taken once the history is all ones and the counter at the resulting index has reached 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_dyn_i | input | 1 | 1 selects table prediction, 0 selects static direction rule |
| pred_pc_i | input | PC_W (32) | PC of the branch being fetched |
| pred_bwd_i | input | 1 | Fetched branch jumps backward |
| pred_taken_o | output | 1 | Predicted direction |
| pred_idx_o | output | IDX_W (8) | Table index used; returned at resolution |
| res_valid_i | input | 1 | A branch resolves this cycle |
| res_idx_i | input | IDX_W (8) | Index saved at prediction time |
| res_taken_i | input | 1 | Actual outcome |
| res_pred_i | input | 1 | Prediction that was used |
| res_bwd_i | input | 1 | Resolved branch jumps backward |
| mispred_o | output | 1 | Previous resolution was mispredicted |
| penalty_o | output | PEN_W (2) | Extra clocks of that misprediction |

## Verification
The bench builds the block with its default parameters: IDX_W=8, PC_LSB=2, PC_W=32 and penalties of 2 and 3. With these values an 8-step run of taken outcomes fills the history, so the loop-training case and history saturation at all ones are reached in a few dozen cycles. The bench can pick a PC that lands on any chosen index, so it drives both saturation limits of a counter directly. Because the penalty constants differ, the bench can tell a backward redirect from a forward one at the port.

// File: rtl/hbp_pkg.sv
package hbp_pkg;
  localparam int CTR_W = 2;
  typedef logic [CTR_W-1:0] ctr_t;

  localparam ctr_t CTR_SNT = 2'd0;
  localparam ctr_t CTR_WNT = 2'd1;
  localparam ctr_t CTR_WT  = 2'd2;
  localparam ctr_t CTR_ST  = 2'd3;

  function automatic ctr_t ctr_step(ctr_t c, logic up);
    ctr_t n;
    n = c;
    if (up && c != CTR_ST) n = c + ctr_t'(1);
    else if (!up && c != CTR_SNT) n = c - ctr_t'(1);
    return n;
  endfunction

  function automatic logic ctr_taken(ctr_t c);
    return c[CTR_W-1];
  endfunction
endpackage

// File: rtl/hbp_index.sv
module hbp_index #(
  parameter int PC_W   = 32,
  parameter int IDX_W  = 8,
  parameter int PC_LSB = 2
) (
  input  logic [PC_W-1:0]  pc_i,
  input  logic [IDX_W-1:0] hist_i,
  output logic [IDX_W-1:0] idx_o
);
  localparam int PC_TOP = PC_LSB + IDX_W;

  // bits outside the hashed window do not contribute
  logic unused_pc_bits;
  assign unused_pc_bits = ^{pc_i[PC_W-1:PC_TOP], pc_i[PC_LSB-1:0]};

  assign idx_o = pc_i[PC_TOP-1:PC_LSB] ^ hist_i;
endmodule

// File: rtl/hbp_history.sv
module hbp_history #(
  parameter int HIST_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              shift_i,
  input  logic              bit_i,
  output logic [HIST_W-1:0] hist_o
);
  logic [HIST_W-1:0] hist_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      hist_q <= '0;
    else if (shift_i) hist_q <= {hist_q[HIST_W-2:0], bit_i};
  end

  assign hist_o = hist_q;

  a_r6_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !shift_i |=> $stable(hist_q));

  a_r6_newest: assert property (@(posedge clk_i) disable iff (!rst_ni)
    shift_i |=> hist_q[0] == $past(bit_i));
endmodule

// File: rtl/hbp_table.sv
module hbp_table
  import hbp_pkg::*;
#(
  parameter int IDX_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [IDX_W-1:0] rd_idx_i,
  output logic             rd_taken_o,
  input  logic             wr_i,
  input  logic [IDX_W-1:0] wr_idx_i,
  input  logic             wr_taken_i
);
  localparam int DEPTH = 1 << IDX_W;

  ctr_t ctr_q [DEPTH];
  ctr_t wr_old;

  for (genvar e = 0; e < DEPTH; e++) begin : g_ent
    logic hit;
    assign hit = wr_i && (wr_idx_i == IDX_W'(e));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)  ctr_q[e] <= CTR_WNT;
      else if (hit) ctr_q[e] <= ctr_step(ctr_q[e], wr_taken_i);
    end
  end

  assign rd_taken_o = ctr_taken(ctr_q[rd_idx_i]);
  assign wr_old     = ctr_q[wr_idx_i];

  a_r5_sat_hi: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && wr_taken_i && wr_old == CTR_ST) |=> ctr_q[$past(wr_idx_i)] == CTR_ST);

  a_r5_sat_lo: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !wr_taken_i && wr_old == CTR_SNT) |=> ctr_q[$past(wr_idx_i)] == CTR_SNT);

  a_r5_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && wr_taken_i && wr_old != CTR_ST) |=>
      ctr_q[$past(wr_idx_i)] == ctr_t'($past(wr_old) + ctr_t'(1)));
endmodule

// File: rtl/hbp_penalty.sv
module hbp_penalty #(
  parameter int PEN_BWD = 2,
  parameter int PEN_FWD = 3,
  parameter int PEN_W   = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             res_valid_i,
  input  logic             res_pred_i,
  input  logic             res_taken_i,
  input  logic             res_bwd_i,
  output logic             mispred_o,
  output logic [PEN_W-1:0] penalty_o
);
  logic             miss;
  logic [PEN_W-1:0] pen_d;

  always_comb begin
    miss  = res_valid_i && (res_pred_i != res_taken_i);
    pen_d = '0;
    if (miss) pen_d = res_bwd_i ? PEN_W'(PEN_BWD) : PEN_W'(PEN_FWD);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mispred_o <= 1'b0;
      penalty_o <= '0;
    end else begin
      mispred_o <= miss;
      penalty_o <= pen_d;
    end
  end

  a_r7_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !res_valid_i |=> !mispred_o && penalty_o == '0);

  a_r7_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mispred_o |-> penalty_o == '0);

  a_r7_cost: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mispred_o |-> (penalty_o == PEN_W'(PEN_BWD) || penalty_o == PEN_W'(PEN_FWD)));
endmodule

// File: rtl/hbp_top.sv
module hbp_top #(
  parameter int PC_W    = 32,
  parameter int IDX_W   = 8,
  parameter int PC_LSB  = 2,
  parameter int PEN_BWD = 2,
  parameter int PEN_FWD = 3,
  parameter int PEN_W   = $clog2(((PEN_FWD > PEN_BWD) ? PEN_FWD : PEN_BWD) + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             mode_dyn_i,
  input  logic [PC_W-1:0]  pred_pc_i,
  input  logic             pred_bwd_i,
  output logic             pred_taken_o,
  output logic [IDX_W-1:0] pred_idx_o,
  input  logic             res_valid_i,
  input  logic [IDX_W-1:0] res_idx_i,
  input  logic             res_taken_i,
  input  logic             res_pred_i,
  input  logic             res_bwd_i,
  output logic             mispred_o,
  output logic [PEN_W-1:0] penalty_o
);
  localparam int HIST_W = IDX_W;

  logic [HIST_W-1:0] hist;
  logic [IDX_W-1:0]  idx;
  logic              dyn_taken;

  hbp_history #(.HIST_W(HIST_W)) u_hist (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .shift_i (res_valid_i),
    .bit_i   (res_taken_i),
    .hist_o  (hist)
  );

  hbp_index #(.PC_W(PC_W), .IDX_W(IDX_W), .PC_LSB(PC_LSB)) u_idx (
    .pc_i   (pred_pc_i),
    .hist_i (hist),
    .idx_o  (idx)
  );

  hbp_table #(.IDX_W(IDX_W)) u_tab (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rd_idx_i   (idx),
    .rd_taken_o (dyn_taken),
    .wr_i       (res_valid_i),
    .wr_idx_i   (res_idx_i),
    .wr_taken_i (res_taken_i)
  );

  hbp_penalty #(.PEN_BWD(PEN_BWD), .PEN_FWD(PEN_FWD), .PEN_W(PEN_W)) u_pen (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .res_valid_i (res_valid_i),
    .res_pred_i  (res_pred_i),
    .res_taken_i (res_taken_i),
    .res_bwd_i   (res_bwd_i),
    .mispred_o   (mispred_o),
    .penalty_o   (penalty_o)
  );

  // static rule: backward taken, forward not taken
  assign pred_taken_o = mode_dyn_i ? dyn_taken : pred_bwd_i;
  assign pred_idx_o   = idx;

  a_r3_static: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mode_dyn_i && pred_bwd_i) |-> pred_taken_o);
endmodule

// File: tb/tb_hbp_top.sv
`timescale 1ns/1ps
module tb_hbp_top;
  localparam int PC_W = 32, IDX_W = 8, PEN_W = 2;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic mode_dyn_i = 1'b1, pred_bwd_i = 1'b0;
  logic [PC_W-1:0] pred_pc_i = '0;
  logic pred_taken_o;
  logic [IDX_W-1:0] pred_idx_o;
  logic res_valid_i = 1'b0, res_taken_i = 1'b0, res_pred_i = 1'b0, res_bwd_i = 1'b0;
  logic [IDX_W-1:0] res_idx_i = '0;
  logic mispred_o;
  logic [PEN_W-1:0] penalty_o;

  hbp_top dut (.*);

  always #5 clk_i = ~clk_i;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  // reference model
  logic [1:0] m_ctr [256];
  logic [7:0] m_hist;
  logic [2:0] exp_q [$];   // {mispred, penalty}

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [7:0] m_idx(logic [PC_W-1:0] pc);
    return pc[9:2] ^ m_hist;
  endfunction

  function automatic logic [PC_W-1:0] pc_for(logic [7:0] idx);
    return {22'h00A5A, (idx ^ m_hist), 2'b00};
  endfunction

  task automatic probe(logic [PC_W-1:0] pc, logic bwd, logic dyn, output logic pred, output logic [7:0] idx);
    logic exp_p;
    @(negedge clk_i);
    res_valid_i = 1'b0;
    pred_pc_i = pc; pred_bwd_i = bwd; mode_dyn_i = dyn;
    #1;
    idx = m_idx(pc);
    exp_p = dyn ? m_ctr[idx][1] : bwd;
    check(pred_idx_o == idx, "R2 index", pred_idx_o, idx);
    check(pred_taken_o == exp_p, dyn ? "R4 dynamic prediction" : "R3 static prediction",
          pred_taken_o, exp_p);
    pred = pred_taken_o;
  endtask

  task automatic resolve(logic [7:0] idx, logic taken, logic pred, logic bwd);
    logic mis;
    @(negedge clk_i);
    res_valid_i = 1'b1; res_idx_i = idx; res_taken_i = taken;
    res_pred_i = pred; res_bwd_i = bwd;
    mis = (pred != taken);
    exp_q.push_back({mis, mis ? (bwd ? 2'd2 : 2'd3) : 2'd0});
    if (taken && m_ctr[idx] != 2'd3) m_ctr[idx] = m_ctr[idx] + 2'd1;
    else if (!taken && m_ctr[idx] != 2'd0) m_ctr[idx] = m_ctr[idx] - 2'd1;
    m_hist = {m_hist[6:0], taken};
    @(negedge clk_i);
    res_valid_i = 1'b0;
  endtask

  task automatic branch(logic [PC_W-1:0] pc, logic bwd, logic dyn, logic taken);
    logic p; logic [7:0] i;
    probe(pc, bwd, dyn, p, i);
    resolve(i, taken, p, bwd);
  endtask

  // monitor: compare resolution results one cycle after they are taken
  initial begin
    @(posedge rst_ni);
    forever begin
      @(posedge clk_i);
      if (res_valid_i) begin
        logic [2:0] e;
        #1;
        e = (exp_q.size() > 0) ? exp_q.pop_front() : 3'b111;
        check(mispred_o == e[2], "R7 mispredict flag", mispred_o, e[2]);
        check(penalty_o == e[1:0], "R7 penalty", penalty_o, e[1:0]);
      end else begin
        #1;
        check(!mispred_o && penalty_o == 0, "R7 idle output zero", penalty_o, 0);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      errors++;
      $display("FAIL watchdog R1 actual running expected finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic p; logic [7:0] i, i0;
    for (int k = 0; k < 256; k++) m_ctr[k] = 2'd1;
    m_hist = '0;
    repeat (3) @(negedge clk_i);
    #1;
    check(mispred_o == 0 && penalty_o == 0, "R8 reset outputs", penalty_o, 0);
    rst_ni = 1'b1;

    // R8/R1: fresh table predicts not taken, history zero
    probe(32'h0000_0034, 1'b1, 1'b1, p, i);
    check(i == 8'h0D, "R8 history cleared", i, 8'h0D);
    check(p == 1'b0, "R1 weakly not-taken reset", p, 0);

    // R3: static rule
    probe(32'h0000_0100, 1'b1, 1'b0, p, i);
    probe(32'h0000_0100, 1'b0, 1'b0, p, i);

    // R7: forward and backward mispredictions, correct one
    branch(32'h0000_0040, 1'b0, 1'b1, 1'b1);   // fwd miss -> 3
    branch(32'h0000_0080, 1'b1, 1'b1, 1'b1);   // bwd miss -> 2
    branch(32'h0000_00C0, 1'b0, 1'b1, 1'b0);   // correct -> 0
    branch(32'h0000_0200, 1'b1, 1'b0, 1'b0);   // static bwd miss -> 2

    // R6: history holds over idle cycles
    probe(32'h0000_0300, 1'b0, 1'b1, p, i0);
    repeat (5) @(negedge clk_i);
    probe(32'h0000_0300, 1'b0, 1'b1, p, i);
    check(i == i0, "R6 history holds without resolution", i, i0);

    // R5: saturation high on a chosen entry
    for (int n = 0; n < 4; n++) resolve(8'h5A, 1'b1, 1'b1, 1'b1);
    probe(pc_for(8'h5A), 1'b0, 1'b1, p, i);
    check(p == 1'b1, "R5 saturated high predicts taken", p, 1);
    resolve(8'h5A, 1'b0, 1'b1, 1'b0);   // 3 -> 2, still taken
    probe(pc_for(8'h5A), 1'b0, 1'b1, p, i);
    check(p == 1'b1, "R5 one step down from 3 stays taken", p, 1);

    // R5: saturation low
    for (int n = 0; n < 4; n++) resolve(8'h33, 1'b0, 1'b0, 1'b0);
    resolve(8'h33, 1'b1, 1'b0, 1'b0);   // 0 -> 1
    probe(pc_for(8'h33), 1'b0, 1'b1, p, i);
    check(p == 1'b0, "R5 floor held then one step up", p, 0);
    resolve(8'h33, 1'b1, 1'b0, 1'b0);   // 1 -> 2
    probe(pc_for(8'h33), 1'b0, 1'b1, p, i);
    check(p == 1'b1, "R5 reaches taken after two rises", p, 1);

    // R9: training while static
    resolve(8'hC1, 1'b1, 1'b0, 1'b0);
    probe(pc_for(8'hC1), 1'b0, 1'b0, p, i);
    probe(pc_for(8'hC1), 1'b0, 1'b1, p, i);
    check(p == 1'b1, "R9 static-mode resolution trained table", p, 1);

    // R10: loop training at a fixed backward PC
    begin
      int misses = 0;
      for (int n = 0; n < 14; n++) begin
        probe(32'h0000_1400, 1'b1, 1'b1, p, i);
        if (!p) misses++;
        resolve(i, 1'b1, p, 1'b1);
      end
      probe(32'h0000_1400, 1'b1, 1'b1, p, i);
      check(i == (8'h00 ^ 8'hFF), "R10 history saturated to ones", i, 8'hFF);
      check(p == 1'b1, "R10 loop predicted taken after training", p, 1);
      check(misses >= 2, "R10 early iterations mispredicted", misses, 2);
    end

    repeat (4) @(negedge clk_i);
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule